// File: doc/BRIEF.md
# Accumulating ADC Result Formatter

This block sits behind a successive-approximation converter and its burst sequencer. It adds each valid 10-bit conversion code into a 16-bit accumulator. When the last sample of a burst arrives, it shapes the sum into a 16-bit result and presents that result as a high byte and a low byte. The accumulator never wraps: a sum that would pass 65535 is held at 65535.

A 3-bit format control selects one of three layouts:
- **Right-justified:** the plain sum.
- **Averaged:** the sum shifted right by 1, 2 or 3 bits, which averages bursts of 2, 4 or 8 samples.
- **Left-justified:** the low ten bits of the sum placed at the top of the word.

The result register changes only when a burst completes. A one-cycle ready strobe marks each update.

Top module: `adcf_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `res_hi`, `res_lo` and `res_ready` are all 0.
- R2: `burst_clr` empties the accumulator. If a valid sample arrives in the same cycle, that sample becomes the first term of the new sum. If no sample arrives, the sum becomes 0.
- R3: The accumulator saturates at 65535 and never wraps to a smaller value.
- R4: With `fmt_ctl` = 000, the result is the 16-bit sum, right-justified. For a single sample this is the 10-bit code in bits 9..0, with bits 15..10 at 0.
- R5: With `fmt_ctl` = 001, 010 or 011, the result is the sum shifted right by 1, 2 or 3 bits respectively. The vacated top bits are 0.
- R6: With `fmt_ctl` = 100, bits 15..6 of the result hold sum bits 9..0, and bits 5..0 are 0.
- R7: The values 101, 110 and 111 of `fmt_ctl` give the same result as 000.
- R8: The result loads only on a cycle where `smp_valid` and `smp_last` are both high. `res_ready` is high for exactly the cycle after that load edge, and the result holds its value until the next load.
- R9: `res_hi` carries result bits 15..8 and `res_lo` carries bits 7..0.
- R10: A cycle in which `burst_clr`, `smp_valid` and `smp_last` are all high produces a result made from that single sample alone.
- R11: While `smp_valid` is low, `smp_code` and `smp_last` have no effect on the sum or the result.
- R12: `fmt_ctl` is sampled only on the loading cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A conversion code is present this cycle |
| smp_code | input | 10 | Unsigned conversion code |
| burst_clr | input | 1 | Start of burst: empty the accumulator |
| smp_last | input | 1 | This sample closes the burst |
| fmt_ctl | input | 3 | Layout and averaging shift select |
| res_hi | output | 8 | Result bits 15..8 |
| res_lo | output | 8 | Result bits 7..0 |
| res_ready | output | 1 | One-cycle strobe after each result load |

## Verification
Three sequencer signals can coincide with a valid sample in one cycle: clear, last, or both. A single-sample burst is the case where all three meet. The bench drives `burst_clr`, `smp_valid` and `smp_last` high together, both immediately after a long burst and after a saturated one. It expects the result to equal that lone sample, formatted, with nothing left over from the previous sum. A behavioural model that applies the clear before the add is compared with both bytes and the strobe on every clock. Saturation is provoked the same way, with the last of seventy full-scale samples landing on the load cycle.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    localparam int CODE_W    = 10;
    localparam int ACC_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int MAX_SHIFT = 3;
    localparam int SH_W      = $clog2(MAX_SHIFT + 1);

    typedef enum logic [1:0] {
        FMT_RIGHT = 2'd0,
        FMT_SHIFT = 2'd1,
        FMT_LEFT  = 2'd2
    } fmt_kind_e;

    typedef struct packed {
        fmt_kind_e         kind;
        logic [SH_W-1:0]   shamt;
    } fmt_sel_t;

    // Map the 3-bit control to a layout; unlisted codes fall back to right-justified.
    function automatic fmt_sel_t decode_ctl(input logic [2:0] ctl);
        fmt_sel_t sel;
        sel.kind  = FMT_RIGHT;
        sel.shamt = '0;
        case (ctl)
            3'b001, 3'b010, 3'b011: begin
                sel.kind  = FMT_SHIFT;
                sel.shamt = SH_W'(ctl[1:0]);
            end
            3'b100: sel.kind = FMT_LEFT;
            default: ;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/adcf_accum.sv
module adcf_accum
    import adcf_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          valid,
    input  logic [CW-1:0] code,
    output logic [AW-1:0] sum_next,
    output logic [AW-1:0] acc_q
);

    logic [AW-1:0] base;
    logic [AW:0]   wide;

    always_comb begin
        base     = clr ? '0 : acc_q;
        wide     = {1'b0, base} + (AW+1)'(code);
        sum_next = wide[AW] ? {AW{1'b1}} : wide[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (valid) begin
            acc_q <= sum_next;
        end else if (clr) begin
            acc_q <= '0;
        end
    end

endmodule

// File: rtl/adcf_shaper.sv
module adcf_shaper
    import adcf_pkg::*;
#(
    parameter int CW  = CODE_W,
    parameter int AW  = ACC_W,
    parameter int MSH = MAX_SHIFT
) (
    input  logic [AW-1:0] sum,
    input  fmt_sel_t      sel,
    output logic [AW-1:0] shaped
);

    localparam int LJ_PAD = AW - CW;

    logic [AW-1:0] shifted [0:MSH];
    logic [AW-1:0] left_form;

    for (genvar g = 0; g <= MSH; g++) begin : g_shift
        assign shifted[g] = sum >> g;
    end

    assign left_form = {sum[CW-1:0], {LJ_PAD{1'b0}}};

    always_comb begin
        case (sel.kind)
            FMT_SHIFT: shaped = shifted[sel.shamt];
            FMT_LEFT:  shaped = left_form;
            default:   shaped = sum;
        endcase
    end

endmodule

// File: rtl/adcf_outreg.sv
module adcf_outreg #(
    parameter int AW = adcf_pkg::ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] res_q,
    output logic          ready_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= load;
            if (load) begin
                res_q <= din;
            end
        end
    end

endmodule

// File: rtl/adcf_top.sv
module adcf_top
    import adcf_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [CW-1:0] smp_code,
    input  logic          burst_clr,
    input  logic          smp_last,
    input  logic [2:0]    fmt_ctl,
    output logic [AW/2-1:0] res_hi,
    output logic [AW/2-1:0] res_lo,
    output logic          res_ready
);

    localparam int HALF = AW / 2;

    logic [AW-1:0] sum_next;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] shaped;
    logic [AW-1:0] res_q;
    fmt_sel_t      sel;
    logic          load;

    assign sel  = decode_ctl(fmt_ctl);
    assign load = smp_valid && smp_last;

    adcf_accum #(.CW(CW), .AW(AW)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr      (burst_clr),
        .valid    (smp_valid),
        .code     (smp_code),
        .sum_next (sum_next),
        .acc_q    (acc_q)
    );

    adcf_shaper #(.CW(CW), .AW(AW), .MSH(MAX_SHIFT)) u_shaper (
        .sum    (sum_next),
        .sel    (sel),
        .shaped (shaped)
    );

    adcf_outreg #(.AW(AW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .din     (shaped),
        .res_q   (res_q),
        .ready_q (res_ready)
    );

    assign res_hi = res_q[AW-1:HALF];
    assign res_lo = res_q[HALF-1:0];

endmodule

// File: rtl/adcf_chk.sv
module adcf_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_valid,
    input logic        smp_last,
    input logic        burst_clr,
    input logic [2:0]  fmt_ctl,
    input logic [7:0]  res_hi,
    input logic [7:0]  res_lo,
    input logic        res_ready,
    input logic [15:0] acc_q
);

    p_ready_cause_r8: assert property (@(posedge clk) disable iff (rst)
        res_ready |-> $past(smp_valid && smp_last));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(smp_valid && smp_last) |=> $stable({res_hi, res_lo}));

    p_left_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_last && fmt_ctl == 3'b100) |=> (res_lo[5:0] == 6'd0));

    p_shift_top_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_last && fmt_ctl == 3'b011) |=> (res_hi[7:5] == 3'd0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !burst_clr) |=> (acc_q >= $past(acc_q)));

endmodule

bind adcf_top adcf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_last  (smp_last),
    .burst_clr (burst_clr),
    .fmt_ctl   (fmt_ctl),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .res_ready (res_ready),
    .acc_q     (acc_q)
);

// File: tb/sim_adcf_top.sv
module sim_adcf_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_code = '0;
    logic       burst_clr = 1'b0;
    logic       smp_last = 1'b0;
    logic [2:0] fmt_ctl = 3'b000;
    logic [7:0] res_hi, res_lo;
    logic       res_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_acc = 0;
    int m_res = 0;
    bit m_rdy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcf_top u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
        .burst_clr(burst_clr), .smp_last(smp_last), .fmt_ctl(fmt_ctl),
        .res_hi(res_hi), .res_lo(res_lo), .res_ready(res_ready)
    );

    function automatic int shape(int s, logic [2:0] c);
        case (c)
            3'b001:  return s / 2;
            3'b010:  return s / 4;
            3'b011:  return s / 8;
            3'b100:  return (s % 1024) * 64;
            default: return s;
        endcase
    endfunction

    task automatic model_step();
        int s;
        if (rst) begin
            m_acc = 0; m_res = 0; m_rdy = 0;
        end else begin
            m_rdy = 0;
            if (smp_valid) begin
                s = (burst_clr ? 0 : m_acc) + int'(smp_code);
                if (s > 65535) s = 65535;
                m_acc = s;
                if (smp_last) begin
                    m_res = shape(s, fmt_ctl);
                    m_rdy = 1;
                end
            end else if (burst_clr) begin
                m_acc = 0;
            end
        end
    endtask

    task automatic check(string tag);
        int got;
        got = {res_hi, res_lo};
        n_checks++;
        if (got != m_res || res_ready != m_rdy) begin
            n_fail++;
            $display("FAIL %s: result=%0h ready=%0b expected result=%0h ready=%0b",
                     tag, got, res_ready, m_res, m_rdy);
        end
    endtask

    task automatic cyc(bit v, int code, bit clr, bit last, logic [2:0] ctl, string tag);
        smp_valid = v; smp_code = 10'(code); burst_clr = clr;
        smp_last = last; fmt_ctl = ctl;
        @(posedge clk);
        model_step();
        #1;
        check(tag);
    endtask

    task automatic burst(int n, int base, logic [2:0] ctl, string tag);
        for (int i = 0; i < n; i++)
            cyc(1, (base + i * 37) % 1024, i == 0, i == n - 1, ctl, tag);
        cyc(0, 0, 0, 0, 3'b111, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1;
        rst = 1'b1;
        cyc(0, 0, 0, 0, 3'b000, "R1");
        cyc(1, 1023, 0, 1, 3'b000, "R1");
        rst = 1'b0;
        cyc(0, 0, 0, 0, 3'b000, "R1");

        cyc(1, 1023, 1, 1, 3'b000, "R4");
        cyc(0, 5, 0, 0, 3'b000, "R8");
        burst(4, 300, 3'b000, "R4 R9");
        burst(2, 1001, 3'b001, "R5");
        burst(4, 777, 3'b010, "R5");
        burst(8, 1023, 3'b011, "R5");
        cyc(1, 1023, 1, 1, 3'b100, "R6 R10");
        cyc(1, 513, 1, 1, 3'b100, "R6");
        burst(3, 111, 3'b101, "R7");
        burst(3, 222, 3'b110, "R7");
        burst(3, 333, 3'b111, "R7");

        cyc(1, 400, 1, 0, 3'b000, "R11");
        cyc(0, 999, 0, 1, 3'b100, "R11");
        cyc(0, 12, 1, 1, 3'b011, "R11");
        cyc(1, 20, 0, 1, 3'b000, "R11");

        cyc(1, 500, 1, 0, 3'b000, "R2");
        cyc(0, 0, 1, 0, 3'b000, "R2");
        cyc(1, 9, 0, 1, 3'b000, "R2");

        for (int i = 0; i < 70; i++)
            cyc(1, 1023, i == 0, i == 69, 3'b000, "R3");
        cyc(1, 1023, 0, 1, 3'b000, "R3");
        cyc(1, 64, 1, 1, 3'b000, "R10");

        cyc(1, 100, 1, 0, 3'b100, "R12");
        cyc(1, 100, 0, 0, 3'b011, "R12");
        cyc(1, 100, 0, 1, 3'b001, "R12");
        for (int i = 0; i < 4; i++)
            cyc(0, i * 200, i == 2, 0, 3'(i), "R8");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule